// File: doc/BRIEF.md
# Speculative Transaction Tracker

This block follows speculative transactions run against a small cache model. Each line of the cache model has one mark bit. It is set by a local access that happens while a transaction is open. A nesting depth counter counts transactions that are open inside one another. A copy of the architectural register bank is saved when the outermost transaction opens.

Coherence traffic is checked against the marks. If an invalidate is applied to a marked line, the transaction is aborted. If a remote read snoop hits a marked line that holds modified data, the transaction is also aborted. An abort clears every mark and returns the depth to zero. It raises a one-cycle pulse and presents the saved register copy so the core can roll back.

When the last open transaction commits, all marks are cleared in one cycle. A nesting error is turned into an abort. Nesting errors are an open request beyond the deepest supported level, or a commit with nothing open. The cause of the most recent abort is kept readable until the next outermost open.

Top module: `txn_track_unit`

## Requirements
- R1: After reset, `abort_pulse` is 0, `txn_active` is 0, `abort_reason` is 0 (none) and `restore_regs` is all zeros.
- R2: An open request raises the depth by one, and `txn_active` is 1 whenever the depth is above zero. Only an open from depth zero copies `arch_regs` into the checkpoint, which `restore_regs` shows. Inner opens leave the checkpoint unchanged.
- R3: A local access (`acc_valid`) marks line `acc_idx` only while a transaction is open. An access while idle marks nothing.
- R4: An invalidate to a marked line causes an abort with reason code 2 on the next cycle. An invalidate to an unmarked line has no effect.
- R5: A remote read snoop with `snp_modified` = 1 to a marked line causes an abort with reason code 3. A snoop with `snp_modified` = 0 has no effect.
- R6: Every abort gives a one-cycle `abort_pulse`, returns the depth to zero, clears all marks and leaves the checkpoint on `restore_regs`.
- R7: A commit lowers the depth by one. The commit that brings it to zero clears every mark in that same cycle and drops `txn_active`.
- R8: When a conflict and a commit arrive in the same cycle, the abort is taken and the commit is dropped.
- R9: An open request at the maximum depth (7 by default), or a commit at depth zero, causes an abort with reason code 4.
- R10: The abort reason is held until the next open from depth zero, which resets it to 0. When several causes hit in one cycle, the priority is: invalidate (2), then snoop (3), then nesting error (4), then explicit (1).
- R11: An explicit abort request while a transaction is open causes an abort with reason code 1. While idle the request is ignored.
- R12: When several commands arrive in one cycle, abort wins over commit, and commit wins over open. Only the winning command acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_begin | input | 1 | Open a (possibly nested) transaction |
| cmd_commit | input | 1 | Commit the innermost open transaction |
| cmd_abort | input | 1 | Explicit abort request |
| acc_valid | input | 1 | Local read or write access |
| acc_idx | input | IDX_W (4) | Line index of the local access |
| inv_valid | input | 1 | Invalidate applied from the invalidate queue |
| inv_idx | input | IDX_W (4) | Line index of the invalidate |
| snp_valid | input | 1 | Remote read snoop |
| snp_idx | input | IDX_W (4) | Line index of the snoop |
| snp_modified | input | 1 | Snooped line is held modified |
| arch_regs | input | NUM_REGS*REG_W (64) | Live register bank, packed register 0 lowest |
| abort_pulse | output | 1 | One-cycle abort indication |
| restore_regs | output | NUM_REGS*REG_W (64) | Checkpointed register bank |
| txn_active | output | 1 | At least one transaction open |
| abort_reason | output | 3 | 0 none, 1 explicit, 2 invalidate, 3 snoop, 4 nesting error |

## Verification
Directed sequences cover the following cases:
- Idle accesses followed by invalidates, which show that marks are gated by the depth.
- Snoops to the same marked line with and without the modified flag, which separate a shared hit from a modified hit.
- Commit and conflict in the same cycle, and several abort causes in one cycle, which expose the priority order.
- A run to the maximum depth and a commit at depth zero, which reach the nesting error path.

Seeded random traffic mixes nested opens, commits and accesses to many lines. Marks therefore build up across lines before invalidates and snoops arrive. This tells apart a design that clears marks only partly, or at the wrong commit level, from a correct one. Every cycle is compared against a bench model built from the requirements.

// File: rtl/txn_pkg.sv
package txn_pkg;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_EXPLICIT = 3'd1,
        RSN_CONF_INV = 3'd2,
        RSN_CONF_RD  = 3'd3,
        RSN_NEST     = 3'd4
    } abort_rsn_e;

endpackage

// File: rtl/txn_tbits.sv
module txn_tbits #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             inv_hit,
    output logic             snp_hit,
    output logic [LINES-1:0] tbits_o
);

    typedef struct packed {
        logic [LINES-1:0] marks;
    } tb_state_t;

    tb_state_t        st_d, st_q;
    logic [LINES-1:0] line_next;

    // per-line next value: clear dominates, otherwise sticky set
    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        assign line_next[gi] = clr_all ? 1'b0
                             : (st_q.marks[gi] | (set_en && (set_idx == IDX_W'(gi))));
    end

    always_comb begin
        st_d       = st_q;
        st_d.marks = line_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inv_hit = st_q.marks[inv_idx];
    assign snp_hit = st_q.marks[snp_idx];
    assign tbits_o = st_q.marks;

endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
    import txn_pkg::*;
#(
    parameter int NEST_MAX = 7,
    parameter int NEST_W   = $clog2(NEST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_begin,
    input  logic              cmd_commit,
    input  logic              cmd_abort,
    input  logic              conf_inv,
    input  logic              conf_rd,
    output logic              clr_marks,
    output logic              mark_ok,
    output logic              take_ckpt,
    output logic [NEST_W-1:0] depth_o,
    output logic              abort_pulse_o,
    output abort_rsn_e        reason_o
);

    localparam logic [NEST_W-1:0] DEPTH_TOP = NEST_W'(NEST_MAX);
    localparam logic [NEST_W-1:0] DEPTH_ONE = NEST_W'(1);

    typedef struct packed {
        logic [NEST_W-1:0] depth;
        logic              pulse;
        abort_rsn_e        reason;
    } nest_state_t;

    nest_state_t st_d, st_q;

    logic sel_abort, sel_commit, sel_begin;
    logic is_idle, explicit_ab, nest_fault, abort_now, final_commit;

    always_comb begin
        // command precedence: abort > commit > begin
        sel_abort    = cmd_abort;
        sel_commit   = !cmd_abort && cmd_commit;
        sel_begin    = !cmd_abort && !cmd_commit && cmd_begin;
        is_idle      = (st_q.depth == '0);
        explicit_ab  = sel_abort && !is_idle;
        nest_fault   = (sel_commit && is_idle) || (sel_begin && (st_q.depth == DEPTH_TOP));
        abort_now    = conf_inv || conf_rd || nest_fault || explicit_ab;
        final_commit = !abort_now && sel_commit && (st_q.depth == DEPTH_ONE);
        clr_marks    = abort_now || final_commit;
        mark_ok      = !is_idle && !clr_marks;
        take_ckpt    = !abort_now && sel_begin && is_idle;

        st_d       = st_q;
        st_d.pulse = abort_now;
        if (abort_now) begin
            st_d.depth = '0;
            if (conf_inv)        st_d.reason = RSN_CONF_INV;
            else if (conf_rd)    st_d.reason = RSN_CONF_RD;
            else if (nest_fault) st_d.reason = RSN_NEST;
            else                 st_d.reason = RSN_EXPLICIT;
        end else if (sel_commit) begin
            st_d.depth = st_q.depth - DEPTH_ONE;
        end else if (sel_begin) begin
            st_d.depth = st_q.depth + DEPTH_ONE;
            if (is_idle) st_d.reason = RSN_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{depth: '0, pulse: 1'b0, reason: RSN_NONE};
        else        st_q <= st_d;
    end

    assign depth_o       = st_q.depth;
    assign abort_pulse_o = st_q.pulse;
    assign reason_o      = st_q.reason;

endmodule

// File: rtl/txn_ckpt.sv
module txn_ckpt #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    parameter int BANK_W   = NUM_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BANK_W-1:0] live_regs,
    output logic [BANK_W-1:0] saved_regs
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] bank;
    } ck_state_t;

    ck_state_t                      st_d, st_q;
    logic [NUM_REGS-1:0][REG_W-1:0] reg_next;

    for (genvar gr = 0; gr < NUM_REGS; gr++) begin : g_reg
        assign reg_next[gr] = take ? live_regs[gr*REG_W +: REG_W] : st_q.bank[gr];
    end

    always_comb begin
        st_d      = st_q;
        st_d.bank = reg_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign saved_regs = st_q.bank;

endmodule

// File: rtl/txn_track_unit.sv
module txn_track_unit
    import txn_pkg::*;
#(
    parameter int LINES    = 16,
    parameter int NEST_MAX = 7,
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    parameter int IDX_W    = $clog2(LINES),
    parameter int BANK_W   = NUM_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_begin,
    input  logic              cmd_commit,
    input  logic              cmd_abort,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              inv_valid,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              snp_modified,
    input  logic [BANK_W-1:0] arch_regs,
    output logic              abort_pulse,
    output logic [BANK_W-1:0] restore_regs,
    output logic              txn_active,
    output logic [2:0]        abort_reason
);

    localparam int NEST_W = $clog2(NEST_MAX + 1);

    logic              inv_hit_w, snp_hit_w;
    logic              conf_inv_w, conf_rd_w;
    logic              clr_w, mark_ok_w, take_w;
    logic [NEST_W-1:0] depth_w;
    logic [LINES-1:0]  tbits_w;
    abort_rsn_e        reason_w;

    assign conf_inv_w = inv_valid && inv_hit_w;
    assign conf_rd_w  = snp_valid && snp_modified && snp_hit_w;

    txn_tbits #(.LINES(LINES), .IDX_W(IDX_W)) u_tbits (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (acc_valid && mark_ok_w),
        .set_idx (acc_idx),
        .clr_all (clr_w),
        .inv_idx (inv_idx),
        .snp_idx (snp_idx),
        .inv_hit (inv_hit_w),
        .snp_hit (snp_hit_w),
        .tbits_o (tbits_w)
    );

    txn_nest_ctrl #(.NEST_MAX(NEST_MAX), .NEST_W(NEST_W)) u_nest (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_begin     (cmd_begin),
        .cmd_commit    (cmd_commit),
        .cmd_abort     (cmd_abort),
        .conf_inv      (conf_inv_w),
        .conf_rd       (conf_rd_w),
        .clr_marks     (clr_w),
        .mark_ok       (mark_ok_w),
        .take_ckpt     (take_w),
        .depth_o       (depth_w),
        .abort_pulse_o (abort_pulse),
        .reason_o      (reason_w)
    );

    txn_ckpt #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .BANK_W(BANK_W)) u_ckpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take_w),
        .live_regs  (arch_regs),
        .saved_regs (restore_regs)
    );

    assign txn_active   = (depth_w != '0);
    assign abort_reason = reason_w;

endmodule

// File: rtl/txn_track_chk.sv
module txn_track_chk #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int NEST_W = 3,
    parameter int BANK_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_begin,
    input logic              cmd_commit,
    input logic              cmd_abort,
    input logic              inv_valid,
    input logic [IDX_W-1:0]  inv_idx,
    input logic              snp_valid,
    input logic [IDX_W-1:0]  snp_idx,
    input logic              snp_modified,
    input logic              abort_pulse,
    input logic [BANK_W-1:0] restore_regs,
    input logic              txn_active,
    input logic [2:0]        abort_reason,
    input logic [LINES-1:0]  tbits,
    input logic [NEST_W-1:0] depth
);

    // R4
    inv_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && tbits[inv_idx]) |=> (abort_pulse && abort_reason == 3'd2));

    // R5
    snp_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_modified && tbits[snp_idx] && !(inv_valid && tbits[inv_idx]))
        |=> (abort_pulse && abort_reason == 3'd3));

    // R6
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (tbits == '0 && depth == '0 && !txn_active));

    // R3
    idle_unmarked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active |-> (tbits == '0));

    // R9
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_commit && !cmd_abort && depth == '0) |=> (abort_pulse && abort_reason == 3'd4));

    // R2
    ckpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_active |=> $stable(restore_regs));

    // R8
    abort_over_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_commit && inv_valid && tbits[inv_idx]) |=> (abort_pulse && !txn_active));

    // R10
    reason_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_begin && !cmd_commit && !cmd_abort && depth == '0)
        |=> (abort_pulse || $stable(abort_reason)));

endmodule

bind txn_track_unit txn_track_chk #(
    .LINES  (LINES),
    .IDX_W  (IDX_W),
    .NEST_W (NEST_W),
    .BANK_W (BANK_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_begin    (cmd_begin),
    .cmd_commit   (cmd_commit),
    .cmd_abort    (cmd_abort),
    .inv_valid    (inv_valid),
    .inv_idx      (inv_idx),
    .snp_valid    (snp_valid),
    .snp_idx      (snp_idx),
    .snp_modified (snp_modified),
    .abort_pulse  (abort_pulse),
    .restore_regs (restore_regs),
    .txn_active   (txn_active),
    .abort_reason (abort_reason),
    .tbits        (tbits_w),
    .depth        (depth_w)
);

// File: tb/txn_track_unit_tb_top.sv
module txn_track_unit_tb_top;

    localparam int LINES  = 16;
    localparam int NMAX   = 7;
    localparam int IDX_W  = 4;
    localparam int BANK_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_begin = 0, cmd_commit = 0, cmd_abort = 0;
    logic              acc_valid = 0, inv_valid = 0, snp_valid = 0, snp_modified = 0;
    logic [IDX_W-1:0]  acc_idx = '0, inv_idx = '0, snp_idx = '0;
    logic [BANK_W-1:0] arch_regs = '0;
    logic              abort_pulse, txn_active;
    logic [BANK_W-1:0] restore_regs;
    logic [2:0]        abort_reason;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model state
    int                m_c;
    logic [LINES-1:0]  m_t;
    logic [BANK_W-1:0] m_ck;
    logic [2:0]        m_rsn;
    logic              m_pulse;

    always #5 clk = ~clk;

    txn_track_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_begin(cmd_begin), .cmd_commit(cmd_commit), .cmd_abort(cmd_abort),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .inv_valid(inv_valid), .inv_idx(inv_idx),
        .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_modified(snp_modified),
        .arch_regs(arch_regs),
        .abort_pulse(abort_pulse), .restore_regs(restore_regs),
        .txn_active(txn_active), .abort_reason(abort_reason)
    );

    function automatic logic [2:0] pick_reason(logic ci, logic cr, logic nf);
        if (ci)      return 3'd2;
        else if (cr) return 3'd3;
        else if (nf) return 3'd4;
        return 3'd1;
    endfunction

    task automatic model_step();
        logic ci, cr, ex, nf, ab, s_ab, s_cm, s_bg;
        ci   = inv_valid && m_t[inv_idx];
        cr   = snp_valid && snp_modified && m_t[snp_idx];
        s_ab = cmd_abort;
        s_cm = !cmd_abort && cmd_commit;
        s_bg = !cmd_abort && !cmd_commit && cmd_begin;
        ex   = s_ab && (m_c > 0);
        nf   = (s_cm && m_c == 0) || (s_bg && m_c == NMAX);
        ab   = ci || cr || ex || nf;
        m_pulse = ab;
        if (ab) begin
            m_c   = 0;
            m_t   = '0;
            m_rsn = pick_reason(ci, cr, nf);
        end else begin
            if (acc_valid && m_c > 0 && !(s_cm && m_c == 1)) m_t[acc_idx] = 1'b1;
            if (s_cm) begin
                m_c = m_c - 1;
                if (m_c == 0) m_t = '0;
            end else if (s_bg) begin
                if (m_c == 0) begin
                    m_ck  = arch_regs;
                    m_rsn = 3'd0;
                end
                m_c = m_c + 1;
            end
        end
    endtask

    task automatic check_all(string tag);
        n_checks++;
        if (abort_pulse !== m_pulse || txn_active !== (m_c > 0) ||
            abort_reason !== m_rsn || restore_regs !== m_ck) begin
            n_fail++;
            $display("FAIL %s: pulse/active/reason/regs act %b/%b/%0d/%h exp %b/%b/%0d/%h",
                     tag, abort_pulse, txn_active, abort_reason, restore_regs,
                     m_pulse, (m_c > 0), m_rsn, m_ck);
        end
    endtask

    task automatic step(logic b, logic c, logic a,
                        logic av, logic [IDX_W-1:0] ai,
                        logic iv, logic [IDX_W-1:0] ii,
                        logic sv, logic sm, logic [IDX_W-1:0] si,
                        logic [BANK_W-1:0] regs, string tag);
        @(negedge clk);
        cmd_begin = b; cmd_commit = c; cmd_abort = a;
        acc_valid = av; acc_idx = ai;
        inv_valid = iv; inv_idx = ii;
        snp_valid = sv; snp_modified = sm; snp_idx = si;
        arch_regs = regs;
        @(posedge clk);
        model_step();
        #1;
        check_all(tag);
    endtask

    task automatic idle(string tag);
        step(0,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, tag);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        m_c = 0; m_t = '0; m_ck = '0; m_rsn = 3'd0; m_pulse = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 reset");

        // R3: idle access marks nothing
        step(0,0,0, 1,4'd3, 0,4'd0, 0,0,4'd0, 64'h0, "R3 idle access");
        step(0,0,0, 0,4'd0, 1,4'd3, 0,0,4'd0, 64'h0, "R3 inv after idle access");

        // R2: outer begin checkpoints, inner does not
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'hAAAA_1111_2222_3333, "R2 outer begin");
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'hBBBB_4444_5555_6666, "R2 inner begin");
        step(0,0,0, 1,4'd5, 0,4'd0, 0,0,4'd0, 64'h0, "R3 mark line 5");
        step(0,0,0, 0,4'd0, 1,4'd6, 0,0,4'd0, 64'h0, "R4 inv unmarked");
        step(0,1,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R7 inner commit");
        step(0,0,0, 0,4'd0, 1,4'd5, 0,0,4'd0, 64'h0, "R4 inv marked");
        idle("R6 after abort");

        // R5: snoop shared vs modified
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'hCCCC_7777_8888_9999, "R2 begin");
        step(0,0,0, 1,4'd7, 0,4'd0, 0,0,4'd0, 64'h0, "R3 mark line 7");
        step(0,0,0, 0,4'd0, 0,4'd0, 1,0,4'd7, 64'h0, "R5 snoop unmodified");
        step(0,0,0, 0,4'd0, 0,4'd0, 1,1,4'd7, 64'h0, "R5 snoop modified");

        // R8: conflict with commit
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h1234_5678_9ABC_DEF0, "R2 begin");
        step(0,0,0, 1,4'd2, 0,4'd0, 0,0,4'd0, 64'h0, "R3 mark line 2");
        step(0,1,0, 0,4'd0, 1,4'd2, 0,0,4'd0, 64'h0, "R8 commit vs conflict");

        // R7: final commit clears marks
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0F0F_0F0F_0F0F_0F0F, "R2 begin");
        step(0,0,0, 1,4'd4, 0,4'd0, 0,0,4'd0, 64'h0, "R3 mark line 4");
        step(0,1,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R7 final commit");
        step(0,0,0, 0,4'd0, 1,4'd4, 0,0,4'd0, 64'h0, "R7 marks cleared");

        // R9 / R10 / R11
        step(0,1,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R9 commit at zero");
        idle("R10 reason held");
        step(0,0,1, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R11 idle abort ignored");
        for (int k = 0; k < NMAX; k++)
            step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h5555_0000_0000_0000 + 64'(k), "R2 nest up");
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R9 begin overflow");
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h7777_0000_0000_0001, "R10 outer begin resets reason");
        step(0,0,1, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R11 explicit abort");

        // R10 priority among causes
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0000_1111_0000_2222, "R2 begin");
        step(0,0,0, 1,4'd1, 0,4'd0, 0,0,4'd0, 64'h0, "R3 mark line 1");
        step(0,0,1, 0,4'd0, 1,4'd1, 1,1,4'd1, 64'h0, "R10 priority inv first");
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R2 begin");
        step(0,0,0, 1,4'd9, 0,4'd0, 0,0,4'd0, 64'h0, "R3 mark line 9");
        step(0,0,1, 0,4'd0, 0,4'd0, 1,1,4'd9, 64'h0, "R10 priority snoop over explicit");

        // R12 command precedence
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R2 begin");
        step(0,1,1, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R12 abort over commit");
        step(1,0,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R2 begin");
        step(1,1,0, 0,4'd0, 0,4'd0, 0,0,4'd0, 64'h0, "R12 commit over begin");

        // seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 40) == 0,
                 ($urandom % 2) == 0, IDX_W'($urandom),
                 ($urandom % 10) == 0, IDX_W'($urandom),
                 ($urandom % 10) == 0, ($urandom % 2) == 0, IDX_W'($urandom),
                 {$urandom, $urandom}, "R2 R4 R5 R6 R7 R9 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule